// File: doc/BRIEF.md
# Two-Port Repeater Configuration Register Bank

This block holds the configuration and status bytes of a two-port signal repeater. A host reaches it over a plain byte bus with an 8-bit address, write data, a write strobe, a read strobe and registered read data. Each port has an identical window of registers. Port 0 sits at 0x00 and port 1 sits 0x40 higher. A handful of global bytes above 0x80 hold interrupt-style event flags, their enables, a revision code and a global control byte.

Each port has eight analog tuning bytes. They come out of reset holding built-in values. When a load sequence ends a fixed number of cycles after reset, a factory-programmed vector can replace them. The repeater's own logic can also rewrite these bytes while running.

The global control byte holds a self-clearing soft-reset bit. That bit re-runs the whole reset and load sequence. The same byte holds one repeater-disable request per port. A disable request does not take effect while the port is connected. It waits until the port reports a disconnect.

Top module: `rptr_cfg_bank`

## Requirements
- R1: `load_done` is low from reset until LOAD_CYCLES cycles after reset is released, then goes high. Host writes made while it is low are discarded.
- R2: Each port has eight tuning bytes, called slots 0 to 7, at window offsets 0x10, 0x30, 0x31, 0x32, 0x33, 0x37, 0x38 and 0x39.
  - Their built-in reset values are 0x50, 0x77, 0x39, 0xD2 (0x92 on port 1), 0x74, 0x40, 0x0C and 0x62.
  - If `otp_valid` is high when the load ends, slot s of port p instead takes byte p*8+s of `otp_vec` (bits [(p*8+s)*8 +: 8]), ANDed with the slot's mask.
  - The slot masks are 0x7F for slot 0, 0xFE for slot 5 and 0xFF for all other slots.
- R3: The following read/write bytes read back the written value ANDed with a mask. Every other bit reads 0.
  - Window offset 0x00: mask 0xEF.
  - Window offset 0x20: mask 0x80.
  - Global 0xB2: mask 0x7C.
  - Global 0xB3: mask 0xFF.
  - Global 0xB4: mask 0xCF.
  - Tuning slots: the slot masks of R2.
- R4: Every address not listed in R2, R3, R5, R7 or R10 reads 0x00, and writes to it change nothing.
- R5: Some bits follow their inputs live on every read:
  - Bit 4 of window offset 0x00 follows `gpio_lvl[p]`.
  - Bits 4:3 of window offset 0x20 follow `port_role[2p+1:2p]`.
  - Bit 0 of window offset 0x20 follows `cdp_stat[p]`.
- R6: A `hw_we` cycle writes `hw_wdata` (ANDed with the slot mask) into the tuning byte that `hw_addr` selects. `hw_addr` uses the same map as the host bus.
  - When the hardware and the host write the same byte in the same cycle, the hardware value is kept.
  - Hardware writes to offsets that are not tuning bytes are ignored.
- R7: `irq_evt[7:0]` sets bits 7:0 of 0xA3, and `irq_evt[11:8]` sets bits 3:0 of 0xA4.
  - Writing 1 to a set bit clears it, and writing 0 leaves it unchanged.
  - If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: Writing 1 to bit 7 of 0xB2 raises `soft_rst_pulse` for exactly one cycle, starting the cycle after the write.
  - The edge after that puts the whole bank in its reset state and restarts the load.
  - Bit 7 always reads 0.
- R9: Bit 6 of 0xB2 requests that port 1 be disabled, and bit 5 requests port 0. `rep_dis[p]` rises one edge after the request is seen together with either `port_conn[p]` low or `disc_evt[p]` high.
  - While the port stays connected with no disconnect event, `rep_dis[p]` stays low.
  - Clearing the request drops `rep_dis[p]` on the next edge.
  - The bus keeps working during all of this.
- R10: 0xB0 reads the REV_ID parameter (default 0x03). Writes to it have no effect.
- R11: `bus_rdata` is loaded on each clock edge where `bus_re` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Registered read data |
| otp_valid | input | 1 | Factory vector present; use it at load end |
| otp_vec | input | NPORTS*64 | Factory default bytes, one per tuning slot |
| hw_we | input | 1 | Hardware update strobe for tuning bytes |
| hw_addr | input | 8 | Hardware update address |
| hw_wdata | input | 8 | Hardware update data |
| gpio_lvl | input | NPORTS | Per-port pin level shown in window offset 0x00 |
| port_role | input | 2*NPORTS | Per-port role code shown in window offset 0x20 |
| cdp_stat | input | NPORTS | Per-port detection status shown in window offset 0x20 |
| port_conn | input | NPORTS | Port currently connected |
| disc_evt | input | NPORTS | One-cycle disconnect event per port |
| irq_evt | input | 12 | Event strobes that set the flag bits |
| load_done | output | 1 | Default load finished; host writes accepted |
| soft_rst_pulse | output | 1 | One-cycle soft-reset pulse |
| rep_dis | output | NPORTS | Effective repeater disable per port |

## Verification
Two pairs of functions in this bank can act on the same state in the same cycle.

The first pair is a hardware tuning update and a host write. The bench drives `hw_we` and `bus_we` on the same clock edge at the same tuning address, reads the byte back, and expects the hardware value. It repeats this at two different addresses in the same cycle and expects both writes to land.

The second pair is an event strobe and a write-one-to-clear on the same flag bit. The bench drives both on one edge and expects the bit to stay set.

All results are compared against a byte-for-byte model kept in the bench, which is also used in full-address sweeps after reset, after pattern writes and after the factory-vector load.

// File: rtl/rptr_cfg_pkg.sv
package rptr_cfg_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int SLOTS  = 8;
  localparam int EVT_W  = 12;
  localparam int EVT_LO = 8;

  localparam logic [5:0] OFF_GPIO = 6'h00;
  localparam logic [5:0] OFF_CFG  = 6'h20;

  localparam logic [7:0] GPIO_RW_MASK = 8'hEF;
  localparam logic [7:0] GCFG_RW_MASK = 8'h7C;
  localparam logic [7:0] ENHI_RW_MASK = 8'hCF;

  localparam logic [7:0] ADDR_STAT_LO = 8'hA3;
  localparam logic [7:0] ADDR_STAT_HI = 8'hA4;
  localparam logic [7:0] ADDR_REV     = 8'hB0;
  localparam logic [7:0] ADDR_GCFG    = 8'hB2;
  localparam logic [7:0] ADDR_EN_LO   = 8'hB3;
  localparam logic [7:0] ADDR_EN_HI   = 8'hB4;

  localparam int SOFT_RST_BIT = 7;
  localparam int DIS_LSB      = 5;

  function automatic logic [5:0] slot_off(input int s);
    case (s)
      0:       return 6'h10;
      1:       return 6'h30;
      2:       return 6'h31;
      3:       return 6'h32;
      4:       return 6'h33;
      5:       return 6'h37;
      6:       return 6'h38;
      default: return 6'h39;
    endcase
  endfunction

  function automatic logic [7:0] slot_mask(input int s);
    case (s)
      0:       return 8'h7F;
      5:       return 8'hFE;
      default: return 8'hFF;
    endcase
  endfunction

  // Built-in defaults assembled from their field values.
  function automatic logic [7:0] slot_dflt(input int port, input int s);
    case (s)
      0:       return {1'b0, 1'b1, 1'b0, 1'b1, 4'h0};
      1:       return {2'd1, 2'd3, 4'd7};
      2:       return {1'b0, 1'b0, 2'd3, 1'b1, 3'd1};
      3:       return {(port == 0) ? 2'd3 : 2'd2, 2'd1, 1'b0, 3'd2};
      4:       return {4'd7, 1'b0, 3'd4};
      5:       return {3'd2, 2'd0, 3'd0};
      6:       return {3'd0, 2'd1, 3'd4};
      default: return {1'b0, 3'd6, 4'd2};
    endcase
  endfunction

endpackage

// File: rtl/rptr_cfg_loader.sv
module rptr_cfg_loader #(
  parameter int LOAD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_i,
  output logic load_strobe,
  output logic load_done
);
  localparam int CW = $clog2(LOAD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOAD_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      cnt       <= '0;
      load_done <= 1'b0;
    end else if (!load_done) begin
      cnt <= cnt + CW'(1);
      if (cnt == LAST) load_done <= 1'b1;
    end
  end

  assign load_strobe = !load_done && (cnt == LAST);

endmodule

// File: rtl/rptr_cfg_port.sv
module rptr_cfg_port
  import rptr_cfg_pkg::*;
#(
  parameter int PORT_IDX = 0
) (
  input  logic                     clk,
  input  logic                     rst_i,
  input  logic                     load_strobe,
  input  logic                     load_done,
  input  logic                     otp_valid,
  input  logic [SLOTS*DATA_W-1:0]  otp_bytes,
  input  logic                     host_we,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [DATA_W-1:0]        host_wdata,
  input  logic                     hw_we,
  input  logic [ADDR_W-1:0]        hw_addr,
  input  logic [DATA_W-1:0]        hw_wdata,
  input  logic                     gpio_lvl,
  input  logic [1:0]               role,
  input  logic                     cdp_stat,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data
);
  localparam logic [1:0] SEL = 2'(PORT_IDX);

  logic host_ok, hw_ok;
  logic [DATA_W-1:0] gpio_cfg;
  logic              cfg_spare;
  logic [SLOTS-1:0][DATA_W-1:0] tune;

  assign host_ok = host_we && load_done && (host_addr[7:6] == SEL);
  assign hw_ok   = hw_we && (hw_addr[7:6] == SEL);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      gpio_cfg  <= '0;
      cfg_spare <= 1'b0;
    end else if (host_ok) begin
      if (host_addr[5:0] == OFF_GPIO) gpio_cfg  <= host_wdata & GPIO_RW_MASK;
      if (host_addr[5:0] == OFF_CFG)  cfg_spare <= host_wdata[7];
    end
  end

  // One byte per tuning slot; precedence: reset, load, hardware, host.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] val;
    logic hw_hit, host_hit;
    assign hw_hit   = hw_ok   && (hw_addr[5:0]   == slot_off(s));
    assign host_hit = host_ok && (host_addr[5:0] == slot_off(s));

    always_ff @(posedge clk) begin
      if (rst_i)
        val <= slot_dflt(PORT_IDX, s);
      else if (load_strobe)
        val <= otp_valid ? (otp_bytes[s*DATA_W +: DATA_W] & slot_mask(s))
                         : slot_dflt(PORT_IDX, s);
      else if (hw_hit)
        val <= hw_wdata & slot_mask(s);
      else if (host_hit)
        val <= host_wdata & slot_mask(s);
    end
    assign tune[s] = val;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[7:6] == SEL) begin
      if (rd_addr[5:0] == OFF_GPIO)
        rd_data = gpio_cfg | {3'b000, gpio_lvl, 4'h0};
      else if (rd_addr[5:0] == OFF_CFG)
        rd_data = {cfg_spare, 2'b00, role, 2'b00, cdp_stat};
      for (int s = 0; s < SLOTS; s++)
        if (rd_addr[5:0] == slot_off(s)) rd_data = tune[s];
    end
  end

endmodule

// File: rtl/rptr_cfg_global.sv
module rptr_cfg_global
  import rptr_cfg_pkg::*;
#(
  parameter int         NPORTS = 2,
  parameter logic [7:0] REV_ID = 8'h03
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rst_i,
  input  logic                 load_done,
  input  logic                 host_we,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [DATA_W-1:0]    host_wdata,
  input  logic [EVT_W-1:0]     irq_evt,
  input  logic [NPORTS-1:0]    port_conn,
  input  logic [NPORTS-1:0]    disc_evt,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 soft_rst_q,
  output logic [NPORTS-1:0]    rep_dis,
  output logic [NPORTS-1:0]    dis_req,
  output logic [EVT_W-1:0]     irq_stat
);
  logic              wr_ok;
  logic [DATA_W-1:0] gcfg, en_lo, en_hi;
  logic [EVT_W-1:0]  clr;

  assign wr_ok = host_we && load_done;

  // Soft reset is cleared only by the external reset so it lasts one cycle.
  always_ff @(posedge clk) begin
    if (rst) soft_rst_q <= 1'b0;
    else     soft_rst_q <= wr_ok && !soft_rst_q && (host_addr == ADDR_GCFG)
                           && host_wdata[SOFT_RST_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      gcfg  <= '0;
      en_lo <= '0;
      en_hi <= '0;
    end else if (wr_ok) begin
      if (host_addr == ADDR_GCFG)  gcfg  <= host_wdata & GCFG_RW_MASK;
      if (host_addr == ADDR_EN_LO) en_lo <= host_wdata;
      if (host_addr == ADDR_EN_HI) en_hi <= host_wdata & ENHI_RW_MASK;
    end
  end

  always_comb begin
    clr = '0;
    if (wr_ok && host_addr == ADDR_STAT_LO) clr[EVT_LO-1:0]     = host_wdata;
    if (wr_ok && host_addr == ADDR_STAT_HI) clr[EVT_W-1:EVT_LO] = host_wdata[EVT_W-EVT_LO-1:0];
  end

  // New events win over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst_i) irq_stat <= '0;
    else       irq_stat <= (irq_stat & ~clr) | irq_evt;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_dis
    assign dis_req[p] = gcfg[DIS_LSB + p];
    always_ff @(posedge clk) begin
      if (rst_i || !dis_req[p])               rep_dis[p] <= 1'b0;
      else if (!port_conn[p] || disc_evt[p])  rep_dis[p] <= 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_STAT_LO: rd_data = irq_stat[EVT_LO-1:0];
      ADDR_STAT_HI: rd_data = {{(DATA_W-(EVT_W-EVT_LO)){1'b0}}, irq_stat[EVT_W-1:EVT_LO]};
      ADDR_REV:     rd_data = REV_ID;
      ADDR_GCFG:    rd_data = gcfg;
      ADDR_EN_LO:   rd_data = en_lo;
      ADDR_EN_HI:   rd_data = en_hi;
      default:      rd_data = '0;
    endcase
  end

endmodule

// File: rtl/rptr_cfg_bank.sv
module rptr_cfg_bank
  import rptr_cfg_pkg::*;
#(
  parameter int         NPORTS      = 2,
  parameter int         LOAD_CYCLES = 16,
  parameter logic [7:0] REV_ID      = 8'h03
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic                           bus_we,
  input  logic                           bus_re,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic                           otp_valid,
  input  logic [NPORTS*SLOTS*DATA_W-1:0] otp_vec,
  input  logic                           hw_we,
  input  logic [ADDR_W-1:0]              hw_addr,
  input  logic [DATA_W-1:0]              hw_wdata,
  input  logic [NPORTS-1:0]              gpio_lvl,
  input  logic [2*NPORTS-1:0]            port_role,
  input  logic [NPORTS-1:0]              cdp_stat,
  input  logic [NPORTS-1:0]              port_conn,
  input  logic [NPORTS-1:0]              disc_evt,
  input  logic [EVT_W-1:0]               irq_evt,
  output logic                           load_done,
  output logic                           soft_rst_pulse,
  output logic [NPORTS-1:0]              rep_dis
);
  localparam int PORT_BITS = SLOTS * DATA_W;

  logic rst_i, load_strobe;
  logic [NPORTS-1:0]             dis_req;
  logic [EVT_W-1:0]              irq_stat;
  logic [DATA_W-1:0]             glb_rd, rd_mux;
  logic [NPORTS-1:0][DATA_W-1:0] port_rd;

  assign rst_i = rst | soft_rst_pulse;

  rptr_cfg_loader #(.LOAD_CYCLES(LOAD_CYCLES)) u_loader (
    .clk         (clk),
    .rst_i       (rst_i),
    .load_strobe (load_strobe),
    .load_done   (load_done)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rptr_cfg_port #(.PORT_IDX(p)) u_port (
      .clk         (clk),
      .rst_i       (rst_i),
      .load_strobe (load_strobe),
      .load_done   (load_done),
      .otp_valid   (otp_valid),
      .otp_bytes   (otp_vec[p*PORT_BITS +: PORT_BITS]),
      .host_we     (bus_we),
      .host_addr   (bus_addr),
      .host_wdata  (bus_wdata),
      .hw_we       (hw_we),
      .hw_addr     (hw_addr),
      .hw_wdata    (hw_wdata),
      .gpio_lvl    (gpio_lvl[p]),
      .role        (port_role[2*p +: 2]),
      .cdp_stat    (cdp_stat[p]),
      .rd_addr     (bus_addr),
      .rd_data     (port_rd[p])
    );
  end

  rptr_cfg_global #(.NPORTS(NPORTS), .REV_ID(REV_ID)) u_global (
    .clk        (clk),
    .rst        (rst),
    .rst_i      (rst_i),
    .load_done  (load_done),
    .host_we    (bus_we),
    .host_addr  (bus_addr),
    .host_wdata (bus_wdata),
    .irq_evt    (irq_evt),
    .port_conn  (port_conn),
    .disc_evt   (disc_evt),
    .rd_addr    (bus_addr),
    .rd_data    (glb_rd),
    .soft_rst_q (soft_rst_pulse),
    .rep_dis    (rep_dis),
    .dis_req    (dis_req),
    .irq_stat   (irq_stat)
  );

  // Decoders return zero when not selected, so a plain OR forms the mux.
  always_comb begin
    rd_mux = glb_rd;
    for (int p = 0; p < NPORTS; p++) rd_mux = rd_mux | port_rd[p];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/rptr_cfg_bank_chk.sv
module rptr_cfg_bank_chk #(
  parameter int NPORTS = 2,
  parameter int EVT_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_re,
  input logic [7:0]        bus_rdata,
  input logic              load_done,
  input logic              soft_rst_pulse,
  input logic [NPORTS-1:0] rep_dis,
  input logic [NPORTS-1:0] dis_req,
  input logic [NPORTS-1:0] port_conn,
  input logic [NPORTS-1:0] disc_evt,
  input logic [EVT_W-1:0]  irq_evt,
  input logic [EVT_W-1:0]  irq_stat
);

  AST_LOAD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (load_done && !soft_rst_pulse) |=> load_done); // R1

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !soft_rst_pulse |=> ((irq_stat & $past(irq_evt)) == $past(irq_evt))); // R7

  AST_SOFT_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    soft_rst_pulse |=> !soft_rst_pulse); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata)); // R11

  for (genvar p = 0; p < NPORTS; p++) begin : g_p
    AST_DIS_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(rep_dis[p]) |-> $past(dis_req[p] && (!port_conn[p] || disc_evt[p]))); // R9
    AST_DIS_RELEASE: assert property (@(posedge clk) disable iff (rst)
      !dis_req[p] |=> !rep_dis[p]); // R9
  end

endmodule

bind rptr_cfg_bank rptr_cfg_bank_chk #(.NPORTS(NPORTS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_re         (bus_re),
  .bus_rdata      (bus_rdata),
  .load_done      (load_done),
  .soft_rst_pulse (soft_rst_pulse),
  .rep_dis        (rep_dis),
  .dis_req        (dis_req),
  .port_conn      (port_conn),
  .disc_evt       (disc_evt),
  .irq_evt        (irq_evt),
  .irq_stat       (irq_stat)
);

// File: tb/test_rptr_cfg_bank.sv
module test_rptr_cfg_bank;
  localparam int LOADC = 16;
  localparam logic [7:0] REV = 8'h03;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic otp_valid = 1'b0;
  logic [127:0] otp_vec;
  logic hw_we = 1'b0;
  logic [7:0] hw_addr = '0, hw_wdata = '0;
  logic [1:0] gpio_lvl = 2'b10, cdp_stat = 2'b01, port_conn = 2'b00, disc_evt = 2'b00;
  logic [3:0] port_role = 4'b1001;
  logic [11:0] irq_evt = '0;
  logic load_done, soft_rst_pulse;
  logic [1:0] rep_dis;

  int n_chk = 0, n_bad = 0;
  logic [7:0] shadow [256];
  logic [11:0] stat_m;

  always #4 clk = ~clk;

  rptr_cfg_bank #(.NPORTS(2), .LOAD_CYCLES(LOADC), .REV_ID(REV)) i_rptr_cfg_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .otp_valid(otp_valid), .otp_vec(otp_vec),
    .hw_we(hw_we), .hw_addr(hw_addr), .hw_wdata(hw_wdata), .gpio_lvl(gpio_lvl),
    .port_role(port_role), .cdp_stat(cdp_stat), .port_conn(port_conn), .disc_evt(disc_evt),
    .irq_evt(irq_evt), .load_done(load_done), .soft_rst_pulse(soft_rst_pulse), .rep_dis(rep_dis));

  // ---- model built from the requirements ----
  function automatic int m_slot(input logic [7:0] a);
    if (a >= 8'h80) return -1;
    case (a[5:0])
      6'h10: return 0; 6'h30: return 1; 6'h31: return 2; 6'h32: return 3;
      6'h33: return 4; 6'h37: return 5; 6'h38: return 6; 6'h39: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] m_tmask(input int s);
    return (s == 0) ? 8'h7F : (s == 5) ? 8'hFE : 8'hFF;
  endfunction

  function automatic logic [7:0] m_def(input int p, input int s);
    case (s)
      0: return 8'h50; 1: return 8'h77; 2: return 8'h39; 3: return (p == 0) ? 8'hD2 : 8'h92;
      4: return 8'h74; 5: return 8'h40; 6: return 8'h0C; default: return 8'h62;
    endcase
  endfunction

  function automatic logic [7:0] m_wmask(input logic [7:0] a);
    int s;
    s = m_slot(a);
    if (s >= 0) return m_tmask(s);
    if (a < 8'h80 && a[5:0] == 6'h00) return 8'hEF;
    if (a < 8'h80 && a[5:0] == 6'h20) return 8'h80;
    case (a)
      8'hB2: return 8'h7C; 8'hB3: return 8'hFF; 8'hB4: return 8'hCF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic reset_model(input logic use_otp);
    for (int a = 0; a < 256; a++) begin
      int s, p;
      s = m_slot(8'(a));
      p = (a >> 6) & 1;
      shadow[a] = 8'h00;
      if (s >= 0)
        shadow[a] = use_otp ? (otp_vec[(p*8+s)*8 +: 8] & m_tmask(s)) : m_def(p, s);
    end
    stat_m = '0;
  endtask

  task automatic m_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'hA3)      stat_m[7:0]  = stat_m[7:0] & ~d;
    else if (a == 8'hA4) stat_m[11:8] = stat_m[11:8] & ~d[3:0];
    else                 shadow[a]    = d & m_wmask(a);
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] a);
    logic [7:0] v;
    int p;
    p = a[6] ? 1 : 0;
    v = shadow[a];
    if (a < 8'h80 && a[5:0] == 6'h00) v = v | {3'b000, gpio_lvl[p], 4'h0};
    if (a < 8'h80 && a[5:0] == 6'h20) v = v | {3'b000, port_role[2*p +: 2], 2'b00, cdp_stat[p]};
    if (a == 8'hB0) v = REV;
    if (a == 8'hA3) v = stat_m[7:0];
    if (a == 8'hA4) v = {4'h0, stat_m[11:8]};
    return v;
  endfunction

  // ---- bus helpers ----
  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    logic [7:0] d;
    bus_rd(a, d);
    check($sformatf("%s addr %h", req, a), d, m_read(a));
  endtask

  task automatic sweep_rd(input string req);
    for (int a = 0; a < 256; a++) rd_chk(req, 8'(a));
  endtask

  task automatic sweep_wr(input logic [7:0] key);
    for (int a = 0; a < 256; a++) begin
      logic [7:0] d;
      if (a == 8'hB2) continue;
      d = 8'(a) ^ key;
      bus_wr(8'(a), d);
      m_write(8'(a), d);
    end
  endtask

  task automatic wait_load();
    repeat (LOADC + 3) @(negedge clk);
    check("R1 load_done high", {7'b0, load_done}, 8'h01);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) otp_vec[k*8 +: 8] = 8'(8'h3C + k * 23);
  end

  // ---- watchdog ----
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 load_done low after reset", {7'b0, load_done}, 8'h00);
    // R1: write during load must be dropped
    bus_wr(8'h00, 8'h2A);
    reset_model(1'b0);
    wait_load();
    // R2 R3 R4 R5 R10: full sweep of reset state with built-in defaults
    sweep_rd("R2/R4/R10 reset sweep");
    // R3 R4: pattern writes everywhere except the control byte
    sweep_wr(8'h5A);
    sweep_rd("R3/R4 pattern sweep");
    sweep_wr(8'hFF);
    sweep_rd("R3/R4 inverted sweep");

    // R5: live status bits
    gpio_lvl = 2'b01; port_role = 4'b0110; cdp_stat = 2'b10;
    rd_chk("R5 port0 gpio", 8'h00);
    rd_chk("R5 port1 gpio", 8'h40);
    rd_chk("R5 port0 cfg", 8'h20);
    rd_chk("R5 port1 cfg", 8'h60);

    // R6: hardware updates and collisions
    @(negedge clk); hw_we = 1'b1; hw_addr = 8'h72; hw_wdata = 8'h3C;
    @(negedge clk); hw_we = 1'b0; shadow[8'h72] = 8'h3C;
    rd_chk("R6 hw only", 8'h72);
    @(negedge clk);
    hw_we = 1'b1; hw_addr = 8'h31; hw_wdata = 8'hEE;
    bus_we = 1'b1; bus_addr = 8'h31; bus_wdata = 8'h11;
    @(negedge clk); hw_we = 1'b0; bus_we = 1'b0; shadow[8'h31] = 8'hEE;
    rd_chk("R6 collision hw wins", 8'h31);
    @(negedge clk);
    hw_we = 1'b1; hw_addr = 8'h70; hw_wdata = 8'h34;
    bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = 8'h12;
    @(negedge clk); hw_we = 1'b0; bus_we = 1'b0;
    shadow[8'h70] = 8'h34; shadow[8'h30] = 8'h12;
    rd_chk("R6 split hw", 8'h70);
    rd_chk("R6 split host", 8'h30);
    @(negedge clk); hw_we = 1'b1; hw_addr = 8'h77; hw_wdata = 8'hFF;
    @(negedge clk); hw_we = 1'b0; shadow[8'h77] = 8'hFE;
    rd_chk("R6 hw masked", 8'h77);
    @(negedge clk); hw_we = 1'b1; hw_addr = 8'h00; hw_wdata = 8'h00;
    @(negedge clk); hw_we = 1'b0;
    rd_chk("R6 hw non-tuning ignored", 8'h00);

    // R7: event flags
    @(negedge clk); irq_evt = 12'h0A5;
    @(negedge clk); irq_evt = '0; stat_m |= 12'h0A5;
    rd_chk("R7 set lo", 8'hA3);
    @(negedge clk); irq_evt = 12'hF00;
    @(negedge clk); irq_evt = '0; stat_m |= 12'hF00;
    rd_chk("R7 set hi", 8'hA4);
    bus_wr(8'hA3, 8'h0F); m_write(8'hA3, 8'h0F);
    rd_chk("R7 clear", 8'hA3);
    bus_wr(8'hA4, 8'h00); m_write(8'hA4, 8'h00);
    rd_chk("R7 write zero", 8'hA4);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'hA3; bus_wdata = 8'h80; irq_evt = 12'h080;
    @(negedge clk); bus_we = 1'b0; irq_evt = '0;
    rd_chk("R7 set beats clear", 8'hA3);

    // R9: deferred disable
    port_conn = 2'b11;
    bus_wr(8'hB2, 8'h60); m_write(8'hB2, 8'h60);
    repeat (3) @(negedge clk);
    check("R9 held while connected", {6'b0, rep_dis}, 8'h00);
    disc_evt = 2'b01;
    @(negedge clk); disc_evt = 2'b00;
    check("R9 port0 after disconnect", {6'b0, rep_dis}, 8'h01);
    port_conn = 2'b01;
    @(negedge clk);
    check("R9 port1 unplugged", {6'b0, rep_dis}, 8'h03);
    rd_chk("R9 bus active", 8'hB2);
    bus_wr(8'hB3, 8'h5C); m_write(8'hB3, 8'h5C);
    rd_chk("R9 bus write active", 8'hB3);
    bus_wr(8'hB2, 8'h20); m_write(8'hB2, 8'h20);
    @(negedge clk);
    check("R9 release port1", {6'b0, rep_dis}, 8'h01);

    // R11: read data holds without a read strobe
    bus_rd(8'hB0, d);
    check("R10 revision", d, REV);
    bus_wr(8'hB0, 8'hFF);
    @(negedge clk); bus_addr = 8'h31;
    @(negedge clk);
    check("R11 hold", bus_rdata, REV);
    rd_chk("R10 revision after write", 8'hB0);

    // R8 R2: soft reset, then load with the factory vector
    otp_valid = 1'b1;
    bus_wr(8'hB2, 8'hA0);
    check("R8 pulse high", {7'b0, soft_rst_pulse}, 8'h01);
    @(negedge clk);
    check("R8 pulse one cycle", {7'b0, soft_rst_pulse}, 8'h00);
    check("R8 load restarted", {7'b0, load_done}, 8'h00);
    check("R8 disable cleared", {6'b0, rep_dis}, 8'h00);
    reset_model(1'b1);
    wait_load();
    sweep_rd("R2/R8 factory-vector sweep");
    sweep_wr(8'hC3);
    sweep_rd("R3 pattern after reload");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule